// File: doc/BRIEF.md
# UV-Erasable Byte-Wide ROM Model

A synthesizable, cycle-level model of a byte-wide programmable ROM whose cells can only be cleared by programming and restored by erasure. An active-low chip enable selects the part and also serves as the program strobe. An active-low output enable gates the data bus. The tri-state bus is split into `din`, `dout` and `dout_en`. Two digital flags stand in for the high-voltage levels. `vpp_hi` marks the programming supply on the output-enable pin. `id_hi` marks the identification voltage on address bit 9.

Erasure is modelled by the reset, which sets every bit to 1. Reads are registered. Data appears a fixed number of cycles after chip enable falls, and this delay stands in for the access time. In programming mode each complete low pulse on chip enable ANDs the data bus into the addressed byte. A pulse held low for too long is rejected and raises a sticky error flag. The array is `2**ADDR_W` bytes. The default is kept small, and a full 64K x 8 part uses `ADDR_W = 16`.

Top module: `uv_rom`

## Requirements
- R1: After reset (erase), every byte of the array reads 0xFF.
- R2: A program pulse stores old AND din into the addressed byte. A 0 on a din bit clears that bit, and a 1 leaves it unchanged. No programming ever turns a 0 into a 1.
- R3: With `vpp_hi` low, chip enable pulses never change the array.
- R4: With `vpp_hi` high, a byte is written once per complete pulse, on the first clock edge that samples `ce_n` high after a low period of 1 to MAX_LOW cycles. While `ce_n` stays high (program inhibit) the array does not change.
- R5: `dout_en` is 1 only when `ce_n` = 0, `oe_n` = 0 and `vpp_hi` = 0, and only once `ce_n` has been sampled low on LAT clock edges. From then on, `dout` shows the byte at the address sampled on the previous edge. Program verify uses this same read.
- R6: With `ce_n` high (standby), `dout_en` is 0 whatever the level of `oe_n`.
- R7: With `ce_n` low and `oe_n` high, `dout_en` is 0, but the access delay keeps counting. Lowering `oe_n` after LAT edges drives data in that same cycle.
- R8: With `id_hi` high, the read returns 0x8F when `addr[0]` = 0 and 0x85 when `addr[0]` = 1. All other address bits are ignored.
- R9: If `ce_n` is sampled low on more than MAX_LOW consecutive edges while `vpp_hi` is high, `strobe_err` rises and stays 1 until reset, and that pulse programs nothing.
- R10: `strobe_err` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array to all ones |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data presented for programming |
| dout | output | 8 | Registered read data |
| dout_en | output | 1 | Data bus drive enable (0 = high impedance) |
| ce_n | input | 1 | Active-low chip enable and program strobe |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming supply present on the output-enable pin |
| id_hi | input | 1 | Identification voltage present on address bit 9 |
| strobe_err | output | 1 | Sticky flag: program strobe held low too long |

## Verification
Some properties are checked by the assertions on every cycle:
- No programming step ever sets a stored bit (R2).
- The error flag rises only during a held strobe in programming mode and never clears (R9).
- The bus is never driven in the cycle that chip enable falls.
- The identification bytes follow `addr[0]` (R8).

Other behaviour can only be shown by the bench's scenarios:
- The erased contents.
- The AND-accumulation of two program patterns over every address.
- The inhibit and no-supply cases.
- The exact access latency.
- The output-disable timing.
- The boundary between a pulse of MAX_LOW cycles, which is accepted, and one of MAX_LOW+1 cycles, which is rejected.

// File: rtl/uv_rom.sv
module uv_rom #(
  parameter int ADDR_W  = 10,
  parameter int LAT     = 3,
  parameter int MAX_LOW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hi,
  output logic              strobe_err
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int CNT_MAX = (LAT > MAX_LOW + 1) ? LAT : MAX_LOW + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);
  localparam logic [CNT_W-1:0] MAXL_C = CNT_W'(MAX_LOW);
  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(CNT_MAX);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] low_cnt;
  logic [7:0]       rd_word, id_byte;
  logic             prog_edge;

  assign rd_word   = mem[addr];
  assign id_byte   = addr[0] ? 8'h85 : 8'h8F;
  assign prog_edge = vpp_hi && ce_n && (low_cnt != '0) && (low_cnt <= MAXL_C);
  assign dout_en   = !ce_n && !oe_n && !vpp_hi && (low_cnt >= LAT_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      strobe_err <= 1'b0;
      dout       <= 8'h00;
    end else begin
      dout <= id_hi ? id_byte : rd_word;
      if (ce_n) low_cnt <= '0;
      else if (low_cnt != SAT_C) low_cnt <= low_cnt + 1'b1;
      if (!ce_n && vpp_hi && low_cnt == MAXL_C) strobe_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_edge) begin
      mem[addr] <= rd_word & din;
    end
  end

  assert_no_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mem[$past(addr)] & ~$past(rd_word)) == 8'h00));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err |=> strobe_err);
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_err) |-> $past(vpp_hi && !ce_n));
  assert_no_drive_at_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> !dout_en);
  assert_id_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && $past(id_hi) && id_hi && $stable(addr[0])) |->
    (dout == (addr[0] ? 8'h85 : 8'h8F)));
endmodule

// File: tb/test_uv_rom.sv
module test_uv_rom;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10, LAT = 3, MAXL = 8, N = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'hFF, dout;
  logic dout_en, ce_n = 1, oe_n = 1, vpp_hi = 0, id_hi = 0, strobe_err;
  int tests = 0, fails = 0, cycles = 0;
  logic [7:0] model [N];

  uv_rom #(.ADDR_W(AW), .LAT(LAT), .MAX_LOW(MAXL)) i_uv_rom (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hi(id_hi), .strobe_err(strobe_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_a(int a); return 8'((a * 37 + 11) & 255); endfunction
  function automatic logic [7:0] pat_b(int a); return 8'(((a * 13) ^ 8'hA5) & 255); endfunction

  task automatic pulse(input int a, input logic [7:0] d, input int n, input logic vp);
    vpp_hi = vp; addr = AW'(a); din = d; ce_n = 0;
    repeat (n) @(negedge clk);
    ce_n = 1;
    @(negedge clk);
    vpp_hi = 0;
  endtask

  task automatic sweep(input string tag, input logic idm);
    int bad = 0, first_a = -1, first_act = 0, first_exp = 0;
    logic [7:0] e;
    id_hi = idm; vpp_hi = 0; oe_n = 0; addr = '0; ce_n = 0;
    repeat (LAT) @(negedge clk);
    for (int a = 0; a < N; a++) begin
      if (a != 0) begin addr = AW'(a); @(negedge clk); end
      e = idm ? ((a & 1) ? 8'h85 : 8'h8F) : model[a];
      if (!dout_en || dout !== e) begin
        if (first_a < 0) begin first_a = a; first_act = dout_en ? int'(dout) : -1; first_exp = e; end
        bad++;
      end
    end
    chk({tag, " sweep"}, bad == 0 ? 0 : first_act, bad == 0 ? 0 : first_exp);
    ce_n = 1; oe_n = 1; id_hi = 0;
    @(negedge clk);
  endtask

  task automatic read1(input string tag, input int a, input int exp);
    addr = AW'(a); oe_n = 0; ce_n = 0;
    repeat (LAT) @(negedge clk);
    chk(tag, dout_en ? int'(dout) : -1, exp);
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < N; a++) model[a] = 8'hFF;
    #1;
    chk("R10 strobe_err at reset", strobe_err, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 strobe_err after reset", strobe_err, 0);
    chk("R6 standby no drive", dout_en, 0);

    // R5 latency and R6 standby with oe low
    addr = 3; oe_n = 0;
    @(negedge clk);
    chk("R6 ce high oe low", dout_en, 0);
    ce_n = 0;
    for (int k = 1; k < LAT; k++) begin
      @(negedge clk);
      chk("R5 before latency", dout_en, 0);
    end
    @(negedge clk);
    chk("R5 at latency", dout_en ? int'(dout) : -1, 8'hFF);
    ce_n = 1; oe_n = 1;
    @(negedge clk);

    // R7 output disable keeps counting
    addr = 7; ce_n = 0; oe_n = 1;
    repeat (LAT) @(negedge clk);
    chk("R7 oe high no drive", dout_en, 0);
    #1 oe_n = 0; #1;
    chk("R7 immediate drive", dout_en, 1);
    ce_n = 1; oe_n = 1;
    @(negedge clk);

    sweep("R1 erased", 0);

    for (int a = 0; a < N; a++) begin
      pulse(a, pat_a(a), 1 + (a % 2), 1);
      model[a] = pat_a(a);
    end
    sweep("R2 pattern A", 0);
    for (int a = 0; a < N; a++) begin
      pulse(a, pat_b(a), 2, 1);
      model[a] = model[a] & pat_b(a);
    end
    sweep("R2 AND accumulate", 0);
    pulse(9, 8'hFF, 1, 1);
    read1("R2 ones leave byte", 9, model[9]);

    // R5 no drive while supply flag high
    vpp_hi = 1; oe_n = 0; ce_n = 0; addr = 4; din = 8'hFF;
    repeat (LAT + 1) @(negedge clk);
    chk("R5 no drive in program mode", dout_en, 0);
    ce_n = 1; oe_n = 1;
    @(negedge clk);
    vpp_hi = 0;

    pulse(20, 8'h00, 2, 0);
    read1("R3 no supply no write", 20, model[20]);

    vpp_hi = 1; addr = 21; din = 8'h00; ce_n = 1;
    repeat (5) @(negedge clk);
    vpp_hi = 0;
    read1("R4 inhibit", 21, model[21]);

    pulse(22, 8'h00, MAXL, 1);
    model[22] = 8'h00;
    read1("R4 max length pulse writes", 22, 0);
    chk("R9 no error at max length", strobe_err, 0);

    pulse(23, 8'h00, MAXL + 1, 1);
    read1("R9 long pulse no write", 23, model[23]);
    chk("R9 error raised", strobe_err, 1);
    repeat (3) @(negedge clk);
    chk("R9 error sticky", strobe_err, 1);

    sweep("R8 id code", 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule